// File: doc/BRIEF.md
# Phase Accumulator Oscillator with Hard Sync

This block is the timing core of one voice in a three-voice tone generator. A 24-bit phase accumulator advances by a 16-bit frequency word on every clock. From it the block derives a registered 12-bit pulse level, set by comparing the top twelve phase bits with a 12-bit width value. It also produces a one-cycle flag that marks the moment the top phase bit turns on.

Voices are chained in a ring for hard sync. Each voice gives its neighbour two combinational signals for the coming edge: a forecast of its own top-bit rise (`rise_nxt_o`), and a flag that says it is itself being synced (`hit_nxt_o`). The neighbour feeds these into `src_rise_i` and `src_hit_i`. Every voice computes its next phase first, and only then applies the clear, so all voices step together at the same edge. A control input holds the phase at zero while it is asserted. The block also provides the top phase bit, optionally modulated by the source voice's top bit, for use by a waveform shaper downstream.

Top module: `osc_voice`

## Requirements
- R1: At each rising clock edge with `test_i` low and no sync clear, `acc_o` becomes (previous `acc_o` + frequency word) modulo 2^24.
- R2: At an edge with `test_i` high, `acc_o` becomes zero. After `test_i` falls, counting resumes from zero.
- R3: `rise_nxt_o` is high when accumulator bit 23 is 0 now and 1 in the value the next edge will load (computed before any sync clear). `msb_rise_o` is that value registered, so it is high for the cycle that follows such an edge.
- R4: At an edge where `sync_en_i`=1, `src_rise_i`=1 and `src_hit_i`=0, `acc_o` becomes zero. A rise of this voice's own top bit on the same edge is still reported on `msb_rise_o`.
- R5: The clear of R4 is suppressed when `src_hit_i`=1 or `sync_en_i`=0. `hit_nxt_o` equals `sync_en_i` AND `src_rise_i`.
- R6: `pulse_o` is 0xFFF when `acc_o[23:12]` is greater than or equal to the pulse width, and 0x000 otherwise. Equality counts as high. A width of 0 gives a constant high level.
- R7: `pulse_o` in a cycle reflects the accumulator and width present in the previous cycle (one register of delay).
- R8: After an edge with `test_i` high, `pulse_o` is 0xFFF whatever the width.
- R9: Writes load the registers at the edge and take effect from the next cycle. `wr_freq_lo_i` loads frequency bits 7:0 and `wr_freq_hi_i` loads bits 15:8, both from `wr_data_i`. `wr_pw_lo_i` loads width bits 7:0 from `wr_data_i[7:0]`. `wr_pw_hi_i` loads width bits 11:8 from `wr_data_i[3:0]`, and `wr_data_i[7:4]` has no effect.
- R10: While `rst_ni` is low, `acc_o`, `msb_rise_o` and `pulse_o` are zero, and the frequency and width registers are cleared.
- R11: `ring_msb_o` equals `acc_o[23]` when `ring_en_i`=0, and `acc_o[23]` XOR NOT `src_msb_i` when `ring_en_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | 8 | Write data byte |
| wr_freq_lo_i | input | 1 | Load frequency low byte |
| wr_freq_hi_i | input | 1 | Load frequency high byte |
| wr_pw_lo_i | input | 1 | Load pulse width low byte |
| wr_pw_hi_i | input | 1 | Load pulse width high nibble |
| test_i | input | 1 | Hold phase at zero, force pulse high |
| sync_en_i | input | 1 | Allow hard sync from source voice |
| ring_en_i | input | 1 | Modulate top bit by source top bit |
| src_rise_i | input | 1 | Source voice top-bit rise forecast |
| src_hit_i | input | 1 | Source voice is itself being synced |
| src_msb_i | input | 1 | Source voice accumulator bit 23 |
| acc_o | output | 24 | Phase accumulator |
| msb_rise_o | output | 1 | Registered top-bit rise flag |
| pulse_o | output | 12 | Registered pulse level |
| ring_msb_o | output | 1 | Top bit after optional modulation |
| rise_nxt_o | output | 1 | Top-bit rise forecast for the next edge |
| hit_nxt_o | output | 1 | This voice is synced at the next edge |

## Verification
The accumulator is visible at `acc_o`, so a wrong phase step, a missed wrap or a missed sync clear appears at the port on the first cycle after the faulty edge. Because the phase keeps accumulating, the error also persists and grows from then on. A wrong width register or comparator shows up on `pulse_o` one cycle later. It is detected only when the phase passes the threshold, so the bench sweeps the phase slowly through exact equality and through both extreme widths. The sync suppression path is driven directly through `src_rise_i` and `src_hit_i`, including a case where a clear lands on the same edge as the voice's own top-bit rise.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int unsigned ACC_W_DEF  = 24;
  localparam int unsigned FREQ_W_DEF = 16;
  localparam int unsigned PW_W_DEF   = 12;

  typedef struct packed {
    logic test;
    logic sync_en;
    logic ring_en;
  } osc_ctrl_t;

  typedef struct packed {
    logic rise;
    logic hit;
  } sync_link_t;
endpackage

// File: rtl/osc_regs.sv
module osc_regs #(
  parameter int unsigned FREQ_W = osc_pkg::FREQ_W_DEF,
  parameter int unsigned PW_W   = osc_pkg::PW_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        wr_data_i,
  input  logic              wr_freq_lo_i,
  input  logic              wr_freq_hi_i,
  input  logic              wr_pw_lo_i,
  input  logic              wr_pw_hi_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic [PW_W-1:0]   pw_o
);
  localparam int unsigned FREQ_HI_W = FREQ_W - 8;
  localparam int unsigned PW_HI_W   = PW_W - 8;

  logic [FREQ_W-1:0] freq_q;
  logic [PW_W-1:0]   pw_q;
  logic              unused_hi_bits;

  assign unused_hi_bits = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_q <= '0;
      pw_q   <= '0;
    end else begin
      if (wr_freq_lo_i) freq_q[7:0]      <= wr_data_i;
      if (wr_freq_hi_i) freq_q[FREQ_W-1:8] <= wr_data_i[FREQ_HI_W-1:0];
      if (wr_pw_lo_i)   pw_q[7:0]        <= wr_data_i;
      if (wr_pw_hi_i)   pw_q[PW_W-1:8]   <= wr_data_i[PW_HI_W-1:0];
    end
  end

  assign freq_o = freq_q;
  assign pw_o   = pw_q;

  // R9: a strobe loads exactly its lane
  a_r9_freq_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_freq_lo_i |=> freq_q[7:0] == $past(wr_data_i));
  a_r9_pw_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pw_hi_i |=> pw_q[PW_W-1:8] == $past(wr_data_i[PW_HI_W-1:0]));
  a_r9_pw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_pw_lo_i && !wr_pw_hi_i) |=> $stable(pw_q));
endmodule

// File: rtl/osc_phase.sv
module osc_phase #(
  parameter int unsigned ACC_W  = osc_pkg::ACC_W_DEF,
  parameter int unsigned FREQ_W = osc_pkg::FREQ_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic              test_i,
  input  logic              sync_en_i,
  input  osc_pkg::sync_link_t src_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              msb_rise_o,
  output osc_pkg::sync_link_t nxt_o
);
  localparam int unsigned MSB = ACC_W - 1;

  logic [ACC_W-1:0] acc_q, acc_step, acc_nxt;
  logic [ACC_W-1:0] freq_ext;
  logic             rise_q, rise_nxt, sync_clr;

  assign freq_ext = {{(ACC_W-FREQ_W){1'b0}}, freq_i};
  assign acc_step = acc_q + freq_ext;
  assign acc_nxt  = test_i ? '0 : acc_step;
  // rise is judged on the pre-sync value so all voices agree
  assign rise_nxt = ~acc_q[MSB] & acc_nxt[MSB];
  assign sync_clr = sync_en_i & src_i.rise & ~src_i.hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      rise_q <= 1'b0;
    end else begin
      acc_q  <= sync_clr ? '0 : acc_nxt;
      rise_q <= rise_nxt;
    end
  end

  assign acc_o      = acc_q;
  assign msb_rise_o = rise_q;
  assign nxt_o.rise = rise_nxt;
  assign nxt_o.hit  = sync_en_i & src_i.rise;

  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && !(sync_en_i && src_i.rise && !src_i.hit))
      |=> acc_q == ACC_W'($past(acc_q) + $past(freq_ext)));
  a_r2_test_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |=> (acc_q == '0) && !rise_q);
  a_r3_rise_from_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> !$past(acc_q[MSB]));
  a_r4_sync_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en_i && src_i.rise && !src_i.hit) |=> acc_q == '0);
endmodule

// File: rtl/osc_pulse.sv
module osc_pulse #(
  parameter int unsigned PW_W = osc_pkg::PW_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PW_W-1:0] phase_i,
  input  logic [PW_W-1:0] pw_i,
  input  logic            test_i,
  output logic [PW_W-1:0] pulse_o
);
  logic [PW_W-1:0] pulse_q;
  logic            above;

  assign above = (phase_i >= pw_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= '0;
    else         pulse_q <= (test_i || above) ? '1 : '0;
  end

  assign pulse_o = pulse_q;

  a_r6_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q == '0) || (pulse_q == '1));
  a_r7_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_i |=> pulse_q == (($past(phase_i) >= $past(pw_i)) ? '1 : '0));
  a_r8_test_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |=> pulse_q == '1);
endmodule

// File: rtl/osc_voice.sv
module osc_voice #(
  parameter int unsigned ACC_W  = osc_pkg::ACC_W_DEF,
  parameter int unsigned FREQ_W = osc_pkg::FREQ_W_DEF,
  parameter int unsigned PW_W   = osc_pkg::PW_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_freq_lo_i,
  input  logic             wr_freq_hi_i,
  input  logic             wr_pw_lo_i,
  input  logic             wr_pw_hi_i,
  input  logic             test_i,
  input  logic             sync_en_i,
  input  logic             ring_en_i,
  input  logic             src_rise_i,
  input  logic             src_hit_i,
  input  logic             src_msb_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             msb_rise_o,
  output logic [PW_W-1:0]  pulse_o,
  output logic             ring_msb_o,
  output logic             rise_nxt_o,
  output logic             hit_nxt_o
);
  localparam int unsigned MSB = ACC_W - 1;

  osc_pkg::osc_ctrl_t  ctrl;
  osc_pkg::sync_link_t src_link, nxt_link;
  logic [FREQ_W-1:0]   freq;
  logic [PW_W-1:0]     pw;
  logic [ACC_W-1:0]    acc;

  assign ctrl     = '{test: test_i, sync_en: sync_en_i, ring_en: ring_en_i};
  assign src_link = '{rise: src_rise_i, hit: src_hit_i};

  osc_regs #(.FREQ_W(FREQ_W), .PW_W(PW_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_data_i    (wr_data_i),
    .wr_freq_lo_i (wr_freq_lo_i),
    .wr_freq_hi_i (wr_freq_hi_i),
    .wr_pw_lo_i   (wr_pw_lo_i),
    .wr_pw_hi_i   (wr_pw_hi_i),
    .freq_o       (freq),
    .pw_o         (pw)
  );

  osc_phase #(.ACC_W(ACC_W), .FREQ_W(FREQ_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .freq_i     (freq),
    .test_i     (ctrl.test),
    .sync_en_i  (ctrl.sync_en),
    .src_i      (src_link),
    .acc_o      (acc),
    .msb_rise_o (msb_rise_o),
    .nxt_o      (nxt_link)
  );

  osc_pulse #(.PW_W(PW_W)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (acc[MSB -: PW_W]),
    .pw_i    (pw),
    .test_i  (ctrl.test),
    .pulse_o (pulse_o)
  );

  assign acc_o      = acc;
  assign ring_msb_o = ctrl.ring_en ? (acc[MSB] ^ ~src_msb_i) : acc[MSB];
  assign rise_nxt_o = nxt_link.rise;
  assign hit_nxt_o  = nxt_link.hit;

  // R5: a voice only reports being synced while its own sync is on
  a_r5_hit_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_nxt_o |-> (sync_en_i && src_rise_i));
endmodule

// File: tb/osc_voice_test.sv
module osc_voice_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [23:0] acc;
    logic        rise;
    logic [11:0] pulse;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        wfl = 0, wfh = 0, wpl = 0, wph = 0;
  logic        tst = 0, sen = 0, ren = 0, srise = 0, shit = 0, smsb = 0;
  logic [23:0] acc;
  logic        msb_rise, ring_msb, rise_nxt, hit_nxt;
  logic [11:0] pulse;

  int errors = 0;
  int checks = 0;
  exp_t q[$];

  logic [23:0] m_acc = '0;
  logic [15:0] m_freq = '0;
  logic [11:0] m_pw = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_voice uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_data_i(wr_data),
    .wr_freq_lo_i(wfl), .wr_freq_hi_i(wfh), .wr_pw_lo_i(wpl), .wr_pw_hi_i(wph),
    .test_i(tst), .sync_en_i(sen), .ring_en_i(ren),
    .src_rise_i(srise), .src_hit_i(shit), .src_msb_i(smsb),
    .acc_o(acc), .msb_rise_o(msb_rise), .pulse_o(pulse),
    .ring_msb_o(ring_msb), .rise_nxt_o(rise_nxt), .hit_nxt_o(hit_nxt)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // driver: called just after a falling edge with inputs already set
  task automatic cycle();
    logic [23:0] nxt;
    logic        rise, clr, rmsb;
    exp_t        e;
    #1;
    nxt  = tst ? 24'h0 : m_acc + {8'h0, m_freq};
    rise = !m_acc[23] && nxt[23];
    clr  = sen && srise && !shit;
    rmsb = ren ? (m_acc[23] ^ ~smsb) : m_acc[23];
    chk(rise_nxt == rise, "R3 rise_nxt", rise_nxt, rise);
    chk(hit_nxt == (sen && srise), "R5 hit_nxt", hit_nxt, sen && srise);
    chk(ring_msb == rmsb, "R11 ring_msb", ring_msb, rmsb);
    e.acc   = clr ? 24'h0 : nxt;
    e.rise  = rise;
    e.pulse = (tst || (m_acc[23:12] >= m_pw)) ? 12'hfff : 12'h000;
    q.push_back(e);
    if (wfl) m_freq[7:0]  = wr_data;
    if (wfh) m_freq[15:8] = wr_data;
    if (wpl) m_pw[7:0]    = wr_data;
    if (wph) m_pw[11:8]   = wr_data[3:0];
    m_acc = e.acc;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr(input int sel, input logic [7:0] d);
    wr_data = d;
    wfl = (sel == 0); wfh = (sel == 1); wpl = (sel == 2); wph = (sel == 3);
    cycle();
    wfl = 0; wfh = 0; wpl = 0; wph = 0;
  endtask

  // monitor: pops one expected item per edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(acc == e.acc, "R1/R2/R4 acc", acc, e.acc);
        chk(msb_rise == e.rise, "R3 msb_rise", msb_rise, e.rise);
        chk(pulse == e.pulse, "R6/R7/R8 pulse", pulse, e.pulse);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(acc == 0, "R10 acc", acc, 0);
    chk(msb_rise == 0, "R10 rise", msb_rise, 0);
    chk(pulse == 0, "R10 pulse", pulse, 0);
    rst_n = 1'b1;
    // R9: upper nibble of the width-high write is ignored
    wr(2, 8'h05); wr(3, 8'hF0);
    wr(0, 8'h00); wr(1, 8'h10);
    run(40);                      // R6 equality crossing at phase 0x005
    // R1 wrap and R3 rise with large step
    wr(2, 8'h00); wr(3, 8'h08);
    wr(0, 8'hFF); wr(1, 8'hFF);
    run(600);
    // R2 / R8 test hold
    tst = 1; run(6); tst = 0; run(20);
    // R4 clear landing on own top-bit rise
    tst = 1; cycle(); tst = 0;
    run(128);
    sen = 1; srise = 1; shit = 0; cycle();
    srise = 0; run(3);
    // R5 suppressed by source being synced
    srise = 1; shit = 1; cycle();
    // R5 suppressed by sync disabled
    sen = 0; shit = 0; cycle();
    srise = 0; run(4);
    // R11 ring modulation of top bit
    ren = 1;
    for (int i = 0; i < 300; i++) begin smsb = i[3]; cycle(); end
    ren = 0; smsb = 1; run(10);
    // R6 width zero: always high
    wr(2, 8'h00); wr(3, 8'h00); run(30);
    // R6 width max with slow step: high only at phase 0xFFF
    wr(0, 8'h00); wr(1, 8'h10);
    wr(2, 8'hFF); wr(3, 8'h0F);
    tst = 1; cycle(); tst = 0;
    run(4200);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule